// File: doc/BRIEF.md
# Dual-Path Clock Root Slice

The slice picks one of eight source enable streams and passes it through a gate, a pre-divider and a post-divider to produce one output enable stream. Every source and the output are single-cycle enable pulses sampled by one system clock. This keeps the whole slice in a single clock domain, so it can be synthesized and tested in that domain.

Software sees one target register. Inside the slice there are two selector paths, A and B. Each path has its own source selector and its own pre-divide value. A toggle names the path that currently drives the post-divider. A register write always rewrites the path that is on standby. The switch first waits for one pulse on the source that the standby path is still wired to, then for one pulse on the new source. Only then does the toggle move the output onto the rewritten path. If the source still wired to the standby path is dead, the switch stalls, and a status flag shows it. Writing the same source twice in a row puts both paths on that source, so the next switch no longer depends on the older source.

A parameter builds a core variant without the pre-dividers. In that variant the selected path drives the post-divider directly.

Top module: `rslice_top`

## Requirements
- R1: After reset, both path selectors read 0, the active path is A (`activePath` = 0), `busy`, `stalled` and `wrDropped` are 0, and the gate is on with both divide values at 1. A pulse on source 0 therefore appears on `outEn` one clock cycle later.
- R2: The `wrData` fields are: bit 0 is the gate, bits 3:1 are the source, bits 6:4 are the pre-divide value minus one, and bits 12:7 are the post-divide value minus one. An accepted write loads the new source into the standby path's selector and leaves the other selector unchanged. `activePath` flips when the switch completes.
- R3: Two back-to-back accepted writes of the same source leave `selA` and `selB` both equal to that source.
- R4: `busy` rises in the cycle after the write. The switch completes only after one pulse on the standby path's old source and then one pulse on the new source. `busy` is low in the cycle after that second pulse. From the second busy cycle onward, `outEn` stays low.
- R5: If the old source of the standby path never pulses, `busy` and `stalled` stay high no matter how the other sources pulse. `stalled` drops once that source pulses.
- R6: A write while `busy` is high is ignored and sets `wrDropped`. The flag stays set until a cycle with `stsRd` high. If a set and a clear fall in the same cycle, the set wins.
- R7: With the gate bit clear, `outEn` produces no pulses while the selected source runs.
- R8: Counting from the completed switch, P pulses on the selected source produce floor(floor(P/pre)/post) output pulses, where pre and post are the divide values. Both counters restart at zero on each switch.
- R9: With `HAS_PRE_DIV` = 0, the pre-divide field has no effect, and P source pulses produce floor(P/post) outputs.
- R10: Pulses on sources other than the selected one produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcEn | input | 8 | Source enable pulse streams, one bit per source |
| wrEn | input | 1 | Target register write strobe |
| wrData | input | 13 | Target register value (fields in R2) |
| stsRd | input | 1 | Status read strobe; clears `wrDropped` |
| outEn | output | 1 | Output enable pulse stream |
| busy | output | 1 | A path switch is in progress |
| stalled | output | 1 | The switch waits on the standby path's old source |
| wrDropped | output | 1 | Sticky flag: a write arrived while busy |
| activePath | output | 1 | Path feeding the post-divider (0 = A, 1 = B) |
| selA | output | 3 | Source held by path A's selector |
| selB | output | 3 | Source held by path B's selector |

## Verification
The bench goes after the hand-over order. A design that waited on the new source first, or on the active path's source, would finish a switch whose old source is dead; the stall test holds every other source high to expose this. A single write followed by a double write shows whether the standby selector, rather than the active one, is the one being rewritten. If that were wrong, the two selectors would not converge and the later switch would hang on a stale source. Divide ratios up to 64, a dropped write during a stall, the gate-off case and the core variant fed the same stimulus catch counters that fail to restart at completion, writes that leak through while busy, and a pre-divider that the core variant still applies.

// File: rtl/rslice_pkg.sv
package rslice_pkg;

  // Strobes from the switch controller to the datapath
  typedef struct packed {
    logic accept;   // register write taken in
    logic loadSel;  // standby path may take the new source
    logic restart;  // hand-over done: flip paths, clear counters
    logic idle;     // no switch in progress
  } slice_stb_t;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_OLD = 2'd1,
    ST_WAIT_NEW = 2'd2
  } slice_state_t;

endpackage

// File: rtl/rslice_ctrl.sv
module rslice_ctrl
  import rslice_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       stsRd,
  input  logic       oldPulse,
  input  logic       newPulse,
  output slice_stb_t stb,
  output logic       busy,
  output logic       stalled,
  output logic       wrDropped
);

  slice_state_t state, stateNext;

  always_comb begin
    stb       = '0;
    stb.idle  = (state == ST_IDLE);
    stateNext = state;
    case (state)
      ST_IDLE: if (wrEn) begin
        stb.accept = 1'b1;
        stateNext  = ST_WAIT_OLD;
      end
      ST_WAIT_OLD: if (oldPulse) begin
        stb.loadSel = 1'b1;
        stateNext   = ST_WAIT_NEW;
      end
      ST_WAIT_NEW: if (newPulse) begin
        stb.restart = 1'b1;
        stateNext   = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wrDropped <= 1'b0;
    end else begin
      state <= stateNext;
      if (wrEn && state != ST_IDLE) wrDropped <= 1'b1;
      else if (stsRd)               wrDropped <= 1'b0;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign stalled = (state == ST_WAIT_OLD);

endmodule

// File: rtl/rslice_dp.sv
module rslice_dp
  import rslice_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int SEL_W       = 3,
  parameter int PRE_W       = 3,
  parameter int POST_W      = 6,
  parameter bit HAS_PRE_DIV = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEn,
  input  slice_stb_t         stb,
  input  logic               wrGate,
  input  logic [SEL_W-1:0]   wrSel,
  input  logic [PRE_W-1:0]   wrPre,
  input  logic [POST_W-1:0]  wrPost,
  output logic               oldPulse,
  output logic               newPulse,
  output logic               outEn,
  output logic               activePath,
  output logic [SEL_W-1:0]   selA,
  output logic [SEL_W-1:0]   selB
);

  logic [SEL_W-1:0]  pathSel [2];
  logic [PRE_W-1:0]  preVal  [2];
  logic [SEL_W-1:0]  pendSel;
  logic [PRE_W-1:0]  prePend;
  logic [POST_W-1:0] postVal;
  logic [POST_W-1:0] postCnt;
  logic              gateOn;
  logic              act;
  logic              run;
  logic [1:0]        pathPulse;
  logic [1:0]        prePulse;
  logic              muxPulse;
  logic              outQ;

  // Configuration and path selectors
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pathSel[0] <= '0;
      pathSel[1] <= '0;
      preVal[0]  <= '0;
      preVal[1]  <= '0;
      pendSel    <= '0;
      prePend    <= '0;
      postVal    <= '0;
      gateOn     <= 1'b1;
      act        <= 1'b0;
    end else begin
      if (stb.accept) begin
        pendSel <= wrSel;
        prePend <= wrPre;
        postVal <= wrPost;
        gateOn  <= wrGate;
      end
      if (stb.loadSel) begin
        pathSel[~act] <= pendSel;
        preVal[~act]  <= prePend;
      end
      if (stb.restart) act <= ~act;
    end
  end

  assign run = stb.idle & gateOn;

  for (genvar p = 0; p < 2; p++) begin : g_path
    assign pathPulse[p] = srcEn[pathSel[p]] & run & (act == 1'(p));
    if (HAS_PRE_DIV) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || stb.restart) preCnt <= '0;
        else if (pathPulse[p])
          preCnt <= (preCnt == preVal[p]) ? '0 : preCnt + 1'b1;
      end
      assign prePulse[p] = pathPulse[p] & (preCnt == preVal[p]);
    end else begin : g_nopre
      logic unusedPreBits;
      assign unusedPreBits = ^preVal[p];
      assign prePulse[p]   = pathPulse[p];
    end
  end

  assign muxPulse = prePulse[act];

  // Shared post-divider with registered output
  always_ff @(posedge clk) begin
    if (!rstN || stb.restart) begin
      postCnt <= '0;
      outQ    <= 1'b0;
    end else begin
      outQ <= muxPulse && (postCnt == postVal);
      if (muxPulse) postCnt <= (postCnt == postVal) ? '0 : postCnt + 1'b1;
    end
  end

  assign oldPulse   = srcEn[pathSel[~act]];
  assign newPulse   = srcEn[pendSel];
  assign outEn      = outQ;
  assign activePath = act;
  assign selA       = pathSel[0];
  assign selB       = pathSel[1];

endmodule

// File: rtl/rslice_top.sv
module rslice_top
  import rslice_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRE_W       = 3,
  parameter int POST_W      = 6,
  parameter bit HAS_PRE_DIV = 1'b1,
  localparam int SEL_W      = $clog2(NUM_SRC),
  localparam int CFG_W      = 1 + SEL_W + PRE_W + POST_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcEn,
  input  logic               wrEn,
  input  logic [CFG_W-1:0]   wrData,
  input  logic               stsRd,
  output logic               outEn,
  output logic               busy,
  output logic               stalled,
  output logic               wrDropped,
  output logic               activePath,
  output logic [SEL_W-1:0]   selA,
  output logic [SEL_W-1:0]   selB
);

  slice_stb_t stb;
  logic       oldPulse;
  logic       newPulse;

  rslice_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .stsRd     (stsRd),
    .oldPulse  (oldPulse),
    .newPulse  (newPulse),
    .stb       (stb),
    .busy      (busy),
    .stalled   (stalled),
    .wrDropped (wrDropped)
  );

  rslice_dp #(
    .NUM_SRC     (NUM_SRC),
    .SEL_W       (SEL_W),
    .PRE_W       (PRE_W),
    .POST_W      (POST_W),
    .HAS_PRE_DIV (HAS_PRE_DIV)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .srcEn      (srcEn),
    .stb        (stb),
    .wrGate     (wrData[0]),
    .wrSel      (wrData[SEL_W:1]),
    .wrPre      (wrData[SEL_W+PRE_W:SEL_W+1]),
    .wrPost     (wrData[CFG_W-1:SEL_W+PRE_W+1]),
    .oldPulse   (oldPulse),
    .newPulse   (newPulse),
    .outEn      (outEn),
    .activePath (activePath),
    .selA       (selA),
    .selB       (selB)
  );

endmodule

// File: rtl/rslice_chk.sv
module rslice_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             outEn,
  input logic             busy,
  input logic             stalled,
  input logic             wrDropped,
  input logic             activePath,
  input logic [SEL_W-1:0] selA,
  input logic [SEL_W-1:0] selB
);

  // R4
  silent_handover_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> !outEn);

  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && busy) |=> wrDropped);

  // R2
  flip_at_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activePath) |-> $fell(busy));

  // R2
  one_selector_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selA) |-> $stable(selB));

  // R5
  stall_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    stalled |-> busy);

endmodule

bind rslice_top rslice_chk #(.SEL_W(SEL_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .outEn      (outEn),
  .busy       (busy),
  .stalled    (stalled),
  .wrDropped  (wrDropped),
  .activePath (activePath),
  .selA       (selA),
  .selB       (selB)
);

// File: tb/rslice_top_tb_top.sv
`timescale 1ns/1ps
module rslice_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  srcEn;
  logic        wrEn;
  logic [12:0] wrData;
  logic        stsRd;
  logic        outEn, busy, stalled, wrDropped, activePath;
  logic [2:0]  selA, selB;
  logic        outEnC, busyC, stalledC, droppedC, actC;
  logic [2:0]  selAC, selBC;

  int checks = 0;
  int errors = 0;
  int outTotal = 0;
  int outTotalC = 0;
  int mSel [2];
  int mAct;

  always #2.5 clk = ~clk;

  rslice_top dut_i (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .wrEn(wrEn), .wrData(wrData),
    .stsRd(stsRd), .outEn(outEn), .busy(busy), .stalled(stalled),
    .wrDropped(wrDropped), .activePath(activePath), .selA(selA), .selB(selB)
  );

  rslice_top #(.HAS_PRE_DIV(1'b0)) core_i (
    .clk(clk), .rstN(rstN), .srcEn(srcEn), .wrEn(wrEn), .wrData(wrData),
    .stsRd(stsRd), .outEn(outEnC), .busy(busyC), .stalled(stalledC),
    .wrDropped(droppedC), .activePath(actC), .selA(selAC), .selB(selBC)
  );

  always @(negedge clk) begin
    #1;
    if (outEn)  outTotal++;
    if (outEnC) outTotalC++;
  end

  // {src, pre-1, post-1, pulses, expected, expected core variant}
  localparam int NVEC = 6;
  localparam int VEC [NVEC][6] = '{
    '{1, 0,  0,   7, 7,  7},
    '{2, 1,  2,  13, 2,  4},
    '{7, 7,  0,  17, 2, 17},
    '{3, 0, 63, 130, 2,  2},
    '{3, 2,  1,  12, 2,  6},
    '{5, 3,  3,  33, 2,  8}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] pack(input int gate, input int src,
                                       input int pre, input int post);
    return {6'(post), 3'(pre), 3'(src), 1'(gate)};
  endfunction

  task automatic pulse(input int s);
    srcEn = 8'(1 << s);
    @(negedge clk);
    srcEn = '0;
  endtask

  task automatic feed(input logic [7:0] mask, input int n,
                      output int got, output int gotC);
    int base  = outTotal;
    int baseC = outTotalC;
    srcEn = mask;
    repeat (n) @(negedge clk);
    srcEn = '0;
    repeat (3) @(negedge clk);
    got  = outTotal - base;
    gotC = outTotalC - baseC;
  endtask

  task automatic doSwitch(input int gate, input int src, input int pre, input int post);
    wrData = pack(gate, src, pre, post);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R4 busy after write", busy, 1);
    pulse(mSel[1-mAct]);
    pulse(src);
    chk("R4 busy clear after handover", busy, 0);
    mSel[1-mAct] = src;
    mAct = 1 - mAct;
    chk("R2 selA", selA, mSel[0]);
    chk("R2 selB", selB, mSel[1]);
    chk("R2 activePath", activePath, mAct);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int got, gotC, q, n;
    rstN = 1'b0; srcEn = '0; wrEn = 1'b0; wrData = '0; stsRd = 1'b0;
    mSel[0] = 0; mSel[1] = 0; mAct = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 stalled", stalled, 0);
    chk("R1 wrDropped", wrDropped, 0);
    chk("R1 selA", selA, 0);
    chk("R1 selB", selB, 0);
    chk("R1 activePath", activePath, 0);
    chk("R1 outEn idle", outEn, 0);
    pulse(0);
    chk("R1 one-cycle latency", outEn, 1);
    @(negedge clk);
    chk("R1 single pulse", outEn, 0);
    feed(8'h01, 5, got, gotC);
    chk("R1 default divide", got, 5);

    // R8 / R9 vector table
    for (int i = 0; i < NVEC; i++) begin
      doSwitch(1, VEC[i][0], VEC[i][1], VEC[i][2]);
      feed(8'(1 << VEC[i][0]), VEC[i][3], got, gotC);
      chk("R8 divided count", got, VEC[i][4]);
      chk("R9 core variant count", gotC, VEC[i][5]);
    end

    // R10 other sources ignored (selected source 5)
    feed(8'hDF, 12, got, gotC);
    chk("R10 unselected sources", got, 0);

    // R3 same source twice
    doSwitch(1, 4, 0, 0);
    doSwitch(1, 4, 0, 0);
    chk("R3 selA on 4", selA, 4);
    chk("R3 selB on 4", selB, 4);
    doSwitch(1, 6, 0, 0);

    // R5 stall on dead old source, R6 dropped write
    q = mSel[1-mAct];
    n = (q + 3) % 8;
    got = outTotal;
    wrData = pack(1, n, 0, 0);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    srcEn = ~8'(1 << q);
    repeat (20) @(negedge clk);
    chk("R5 busy while stalled", busy, 1);
    chk("R5 stalled flag", stalled, 1);
    wrData = pack(1, (n + 1) % 8, 0, 0);
    wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    chk("R6 wrDropped set", wrDropped, 1);
    repeat (4) @(negedge clk);
    srcEn = '0;
    repeat (2) @(negedge clk);
    chk("R4 no output during switch", outTotal - got, 0);
    pulse(q);
    chk("R5 stall released", stalled, 0);
    pulse(n);
    chk("R5 switch completes", busy, 0);
    mSel[1-mAct] = n;
    mAct = 1 - mAct;
    chk("R6 dropped write ignored", (mAct == 0) ? selA : selB, n);
    chk("R6 dropped flag sticky", wrDropped, 1);
    stsRd = 1'b1;
    @(negedge clk);
    stsRd = 1'b0;
    chk("R6 cleared by status read", wrDropped, 0);

    // R7 gate off
    doSwitch(0, 2, 0, 0);
    feed(8'h04, 10, got, gotC);
    chk("R7 gated output", got, 0);
    chk("R7 gated core output", gotC, 0);
    doSwitch(1, 2, 0, 0);
    feed(8'h04, 4, got, gotC);
    chk("R7 gate restored", got, 4);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule